// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Channel Array

This block is a bank of capture/compare channels that share two independent 16-bit time bases, timer A and timer B. Each timer counts up and, after it reaches 0xFFFF, reloads from its own reload register, so the reload value sets the period. Each timer takes its count clock from one of three places: a prescaled version of the system clock, a one-cycle overflow pulse from a neighbouring timer module, or (timer A only) rising edges on an external count pin.

Each channel is bound to one of the two timers and works in one of two ways. In capture mode it stores the bound timer's value when the chosen edge arrives on its input pin. In compare mode it watches the bound timer and, when the timer steps onto the channel's value, it sets or toggles the channel's output pin or only raises a flag. Every capture and every match sets a sticky interrupt flag for that channel. A single write port holds all configuration. Channel values, pin outputs, flags and both timer counts are visible as outputs.

Top module: `ccu_array`

## Requirements
- R1: After a synchronous reset, both timers, every channel value, every output pin and every interrupt flag read 0, and both timers are stopped.
- R2: The timer control word at address 0x20 (timer A) or 0x21 (timer B) holds the prescale code in bits [2:0] and the clock source in bits [4:3]: 0 prescaler, 1 overflow pulse, 2 external count, 3 stopped. A control write restarts the prescaler. With the prescaler source, the timer advances once every 8<<code clocks counted from the write edge.
- R3: A timer at 0xFFFF that receives a count loads its reload value (0x24 for A, 0x25 for B). A reload of 0 gives the full 65536-count period. Writes to 0x22/0x23 load the timer directly.
- R4: With source 1, a timer advances by one on each clock in which its overflow pulse input (ovf_a_in or ovf_b_in) is high.
- R5: With source 2, timer A advances once per rising edge of tcnt_a_in. The input passes through two flip-flops, so the timer changes on the third clock edge after the pin rises. Timer B set to source 2 does not count.
- R6: The channel mode at address 0x10+i uses bits [2:0]: 1 captures on a rising edge, 2 on a falling edge, 3 on both edges. Pins are synchronised through two flip-flops. The channel value (written directly at address 0x00+i) takes the bound timer's value on the third clock edge after the pin changes.
- R7: Mode bit 3 binds the channel to timer B when 1 and to timer A when 0, for both capture and compare.
- R8: Every capture sets that channel's interrupt flag.
- R9: Compare modes are 4 (flag only), 5 (set pin) and 6 (toggle pin). A match sets the flag and applies the pin action on the same clock edge that the bound timer takes the matching value.
- R10: A match fires only when a count step produces the value. A timer held at the matching value fires no further events, and a direct timer write of the matching value fires none.
- R11: Writing to address 0x26 clears the interrupt flags whose bits are 1 in the write data and leaves the other flags unchanged.
- R12: A mode write clears that channel's output pin. Modes 0 and 7 ignore pin edges and matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 6 | Configuration write address |
| wr_data | input | TW | Configuration write data |
| cc_pin_in | input | NCH | Channel input pins (asynchronous) |
| tcnt_a_in | input | 1 | External count pin for timer A (asynchronous) |
| ovf_a_in | input | 1 | Overflow pulse from another module, timer A |
| ovf_b_in | input | 1 | Overflow pulse from another module, timer B |
| cc_pin_out | output | NCH | Channel compare output pins |
| cc_irq | output | NCH | Sticky per-channel interrupt flags |
| cc_val | output | NCH*TW | Channel registers, channel i in bits [i*TW +: TW] |
| timer_a | output | TW | Timer A count |
| timer_b | output | TW | Timer B count |

## Verification
The hardest case to reach is the single-shot property of compare: a match must fire on the step into the value and never again while the count rests there. It also must not fire when the timer is loaded with that value. The bench clocks timer B from its overflow-pulse input, so every step comes from a pulse it drives itself. It parks the timer on the matching value with a toggle channel attached and checks that the pin holds. It then writes the matching value straight into the timer, and finally wraps through a reload of 4 so the value is reached again by a real step. Capture latency is pinned down in the same deterministic way: the timers are stopped and the channel value is sampled on the second and third edges after each pin change.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic [1:0] {
    SRC_PRESC = 2'd0,
    SRC_OVF   = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_OFF   = 2'd3
  } clk_src_e;

  typedef enum logic [2:0] {
    M_OFF     = 3'd0,
    M_CAP_R   = 3'd1,
    M_CAP_F   = 3'd2,
    M_CAP_B   = 3'd3,
    M_CMP_IRQ = 3'd4,
    M_CMP_SET = 3'd5,
    M_CMP_TGL = 3'd6,
    M_RSVD    = 3'd7
  } ch_mode_e;

  localparam logic [5:0] A_MODE_BASE = 6'h10;
  localparam logic [5:0] A_CTL_A     = 6'h20;
  localparam logic [5:0] A_CTL_B     = 6'h21;
  localparam logic [5:0] A_CNT_A     = 6'h22;
  localparam logic [5:0] A_CNT_B     = 6'h23;
  localparam logic [5:0] A_RLD_A     = 6'h24;
  localparam logic [5:0] A_RLD_B     = 6'h25;
  localparam logic [5:0] A_IRQ_CLR   = 6'h26;
endpackage

// File: rtl/ccu_sync.sv
module ccu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= '0;
      q   <= '0;
      q_d <= '0;
    end else begin
      s1  <= d;
      q   <= s1;
      q_d <= q;
    end
  end
endmodule

// File: rtl/ccu_timebase.sv
module ccu_timebase
  import ccu_pkg::*;
#(
  parameter int TW      = 16,
  parameter int PSW     = 3,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [PSW+1:0] ctl_wdata,
  input  logic          cnt_we,
  input  logic [TW-1:0] cnt_wdata,
  input  logic          rld_we,
  input  logic [TW-1:0] rld_wdata,
  input  logic          ovf_pulse,
  input  logic          ext_rise,
  output logic [TW-1:0] cnt,
  output logic          tick,
  output logic [TW-1:0] nxt
);
  localparam int BASE_SH = 3;
  localparam int PCW     = BASE_SH + (1 << PSW) - 1;

  clk_src_e       src;
  logic [PSW-1:0] ps;
  logic [TW-1:0]  rld;
  logic [PCW-1:0] pre;
  logic [PCW-1:0] pmask;
  logic           raw_tick;

  assign pmask = (PCW'(1) << (ps + BASE_SH)) - PCW'(1);

  always_comb begin
    unique case (src)
      SRC_PRESC: raw_tick = ((pre & pmask) == pmask);
      SRC_OVF:   raw_tick = ovf_pulse;
      SRC_EXT:   raw_tick = HAS_EXT ? ext_rise : 1'b0;
      default:   raw_tick = 1'b0;
    endcase
  end

  // a direct load takes priority and is not a count step
  assign tick = raw_tick & ~cnt_we;
  assign nxt  = (cnt == '1) ? rld : cnt + TW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= SRC_OFF;
      ps  <= '0;
      rld <= '0;
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= ctl_we ? '0 : pre + PCW'(1);
      if (ctl_we) begin
        ps  <= ctl_wdata[PSW-1:0];
        src <= clk_src_e'(ctl_wdata[PSW+1:PSW]);
      end
      if (rld_we) rld <= rld_wdata;
      if (cnt_we)    cnt <= cnt_wdata;
      else if (tick) cnt <= nxt;
    end
  end
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
  import ccu_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          val_we,
  input  logic [TW-1:0] val_wdata,
  input  logic          mode_we,
  input  logic [3:0]    mode_wdata,
  input  logic [TW-1:0] cnt_a,
  input  logic          tick_a,
  input  logic [TW-1:0] nxt_a,
  input  logic [TW-1:0] cnt_b,
  input  logic          tick_b,
  input  logic [TW-1:0] nxt_b,
  input  logic          rise,
  input  logic          fall,
  input  logic          clr,
  output logic [TW-1:0] val,
  output logic          pin,
  output logic          irq
);
  ch_mode_e      mode;
  logic          sel_b;
  logic [TW-1:0] cnt_s, nxt_s;
  logic          tick_s, cap_hit, cmp_hit, is_cmp;

  assign cnt_s  = sel_b ? cnt_b  : cnt_a;
  assign nxt_s  = sel_b ? nxt_b  : nxt_a;
  assign tick_s = sel_b ? tick_b : tick_a;

  assign cap_hit = ((mode == M_CAP_R) && rise) ||
                   ((mode == M_CAP_F) && fall) ||
                   ((mode == M_CAP_B) && (rise || fall));
  assign is_cmp  = (mode == M_CMP_IRQ) || (mode == M_CMP_SET) || (mode == M_CMP_TGL);
  assign cmp_hit = is_cmp && tick_s && (nxt_s == val);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= M_OFF;
      sel_b <= 1'b0;
      val   <= '0;
      pin   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (mode_we) begin
        mode  <= ch_mode_e'(mode_wdata[2:0]);
        sel_b <= mode_wdata[3];
      end
      if (val_we)       val <= val_wdata;
      else if (cap_hit) val <= cnt_s;
      if (mode_we) pin <= 1'b0;
      else if (cmp_hit && mode == M_CMP_SET) pin <= 1'b1;
      else if (cmp_hit && mode == M_CMP_TGL) pin <= ~pin;
      if (cap_hit || cmp_hit) irq <= 1'b1;
      else if (clr)           irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ccu_array.sv
module ccu_array
  import ccu_pkg::*;
#(
  parameter int NCH = 16,
  parameter int TW  = 16,
  parameter int PSW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [5:0]        wr_addr,
  input  logic [TW-1:0]     wr_data,
  input  logic [NCH-1:0]    cc_pin_in,
  input  logic              tcnt_a_in,
  input  logic              ovf_a_in,
  input  logic              ovf_b_in,
  output logic [NCH-1:0]    cc_pin_out,
  output logic [NCH-1:0]    cc_irq,
  output logic [NCH*TW-1:0] cc_val,
  output logic [TW-1:0]     timer_a,
  output logic [TW-1:0]     timer_b
);
  logic [NCH-1:0] pin_q, pin_qd;
  logic           tc_q, tc_qd;
  logic           tick_a, tick_b;
  logic [TW-1:0]  nxt_a, nxt_b;

  ccu_sync #(.W(NCH)) u_pin_sync (
    .clk(clk), .rst(rst), .d(cc_pin_in), .q(pin_q), .q_d(pin_qd)
  );

  ccu_sync #(.W(1)) u_tcnt_sync (
    .clk(clk), .rst(rst), .d(tcnt_a_in), .q(tc_q), .q_d(tc_qd)
  );

  ccu_timebase #(.TW(TW), .PSW(PSW), .HAS_EXT(1'b1)) u_tmr_a (
    .clk(clk), .rst(rst),
    .ctl_we(wr_en && wr_addr == A_CTL_A), .ctl_wdata(wr_data[PSW+1:0]),
    .cnt_we(wr_en && wr_addr == A_CNT_A), .cnt_wdata(wr_data),
    .rld_we(wr_en && wr_addr == A_RLD_A), .rld_wdata(wr_data),
    .ovf_pulse(ovf_a_in), .ext_rise(tc_q & ~tc_qd),
    .cnt(timer_a), .tick(tick_a), .nxt(nxt_a)
  );

  ccu_timebase #(.TW(TW), .PSW(PSW), .HAS_EXT(1'b0)) u_tmr_b (
    .clk(clk), .rst(rst),
    .ctl_we(wr_en && wr_addr == A_CTL_B), .ctl_wdata(wr_data[PSW+1:0]),
    .cnt_we(wr_en && wr_addr == A_CNT_B), .cnt_wdata(wr_data),
    .rld_we(wr_en && wr_addr == A_RLD_B), .rld_wdata(wr_data),
    .ovf_pulse(ovf_b_in), .ext_rise(1'b0),
    .cnt(timer_b), .tick(tick_b), .nxt(nxt_b)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ccu_channel #(.TW(TW)) u_ch (
      .clk(clk), .rst(rst),
      .val_we(wr_en && wr_addr == 6'(i)), .val_wdata(wr_data),
      .mode_we(wr_en && wr_addr == A_MODE_BASE + 6'(i)), .mode_wdata(wr_data[3:0]),
      .cnt_a(timer_a), .tick_a(tick_a), .nxt_a(nxt_a),
      .cnt_b(timer_b), .tick_b(tick_b), .nxt_b(nxt_b),
      .rise(pin_q[i] & ~pin_qd[i]), .fall(~pin_q[i] & pin_qd[i]),
      .clr(wr_en && wr_addr == A_IRQ_CLR && wr_data[i]),
      .val(cc_val[i*TW +: TW]), .pin(cc_pin_out[i]), .irq(cc_irq[i])
    );
  end
endmodule

// File: rtl/ccu_array_chk.sv
module ccu_array_chk
  import ccu_pkg::*;
#(
  parameter int NCH = 16,
  parameter int TW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [5:0]        wr_addr,
  input logic [NCH-1:0]    cc_pin_out,
  input logic [NCH-1:0]    cc_irq,
  input logic [NCH*TW-1:0] cc_val,
  input logic [TW-1:0]     timer_a,
  input logic [TW-1:0]     timer_b
);
  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_IRQ_CLR) |=> ((cc_irq & $past(cc_irq)) == $past(cc_irq)));

  // R9
  pin_rise_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cc_pin_out & ~$past(cc_pin_out) & ~cc_irq) == '0));

  // R3
  timer_a_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_CNT_A) |=>
      (timer_a == $past(timer_a) || timer_a == $past(timer_a) + TW'(1) || $past(timer_a) == '1));

  // R3
  timer_b_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_CNT_B) |=>
      (timer_b == $past(timer_b) || timer_b == $past(timer_b) + TW'(1) || $past(timer_b) == '1));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R8
    val_change_flag_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == 6'(i)) |=>
        (cc_val[i*TW +: TW] == $past(cc_val[i*TW +: TW]) || cc_irq[i]));
  end
endmodule

bind ccu_array ccu_array_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .cc_pin_out(cc_pin_out), .cc_irq(cc_irq), .cc_val(cc_val),
  .timer_a(timer_a), .timer_b(timer_b)
);

// File: tb/tb_ccu_array.sv
`timescale 1ns/1ps
module tb_ccu_array;
  localparam int NCH = 16;
  localparam int TW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [5:0]        wr_addr = '0;
  logic [TW-1:0]     wr_data = '0;
  logic [NCH-1:0]    cc_pin_in = '0;
  logic              tcnt_a_in = 1'b0;
  logic              ovf_a_in = 1'b0;
  logic              ovf_b_in = 1'b0;
  logic [NCH-1:0]    cc_pin_out;
  logic [NCH-1:0]    cc_irq;
  logic [NCH*TW-1:0] cc_val;
  logic [TW-1:0]     timer_a;
  logic [TW-1:0]     timer_b;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ccu_array #(.NCH(NCH), .TW(TW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cc_pin_in(cc_pin_in), .tcnt_a_in(tcnt_a_in), .ovf_a_in(ovf_a_in), .ovf_b_in(ovf_b_in),
    .cc_pin_out(cc_pin_out), .cc_irq(cc_irq), .cc_val(cc_val),
    .timer_a(timer_a), .timer_b(timer_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [TW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_a();
    @(negedge clk); ovf_a_in = 1'b1;
    @(negedge clk); ovf_a_in = 1'b0;
  endtask

  task automatic pulse_b();
    @(negedge clk); ovf_b_in = 1'b1;
    @(negedge clk); ovf_b_in = 1'b0;
  endtask

  function automatic logic [TW-1:0] chv(input int i);
    return cc_val[i*TW +: TW];
  endfunction

  task automatic t_reset();
    check("R1 timer_a", 32'(timer_a), 0);
    check("R1 timer_b", 32'(timer_b), 0);
    check("R1 irq", 32'(cc_irq), 0);
    check("R1 pins", 32'(cc_pin_out), 0);
    check("R1 ch0 value", 32'(chv(0)), 0);
    repeat (20) @(negedge clk);
    check("R1 timers stopped", 32'(timer_a), 0);
  endtask

  task automatic t_prescaler();
    wr(6'h20, 16'h0000);            // R2 divide by 8
    repeat (39) @(posedge clk); @(negedge clk);
    check("R2 div8 at 39", 32'(timer_a), 4);
    @(posedge clk); @(negedge clk);
    check("R2 div8 at 40", 32'(timer_a), 5);
    wr(6'h20, 16'h0018);
    wr(6'h22, 16'h0000);
    wr(6'h20, 16'h0002);            // R2 divide by 32
    repeat (63) @(posedge clk); @(negedge clk);
    check("R2 div32 at 63", 32'(timer_a), 1);
    @(posedge clk); @(negedge clk);
    check("R2 div32 at 64", 32'(timer_a), 2);
    wr(6'h20, 16'h0018);
  endtask

  task automatic t_reload();
    wr(6'h20, 16'h0008);
    wr(6'h24, 16'hFFF0);
    wr(6'h22, 16'hFFFE);
    pulse_a(); check("R4 pulse step", 32'(timer_a), 32'hFFFF);
    pulse_a(); check("R3 reload", 32'(timer_a), 32'hFFF0);
    pulse_a(); check("R3 after reload", 32'(timer_a), 32'hFFF1);
    wr(6'h24, 16'h0000);
    wr(6'h22, 16'hFFFF);
    pulse_a(); check("R3 full period wrap", 32'(timer_a), 0);
    wr(6'h21, 16'h0008);
    pulse_b(); check("R4 timer_b pulse", 32'(timer_b), 1);
    check("R4 timer_a unaffected by ovf_b", 32'(timer_a), 0);
    wr(6'h20, 16'h0018);
    wr(6'h21, 16'h0018);
  endtask

  task automatic t_extcnt();
    wr(6'h22, 16'h0000);
    wr(6'h20, 16'h0010);
    wr(6'h23, 16'h0007);
    wr(6'h21, 16'h0010);
    @(negedge clk); tcnt_a_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 not yet counted", 32'(timer_a), 0);
    @(negedge clk);
    check("R5 third edge", 32'(timer_a), 1);
    repeat (5) @(negedge clk);
    check("R5 level held", 32'(timer_a), 1);
    tcnt_a_in = 1'b0;
    repeat (3) @(negedge clk);
    tcnt_a_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 second rise", 32'(timer_a), 2);
    check("R5 timer_b no ext count", 32'(timer_b), 7);
    tcnt_a_in = 1'b0;
    wr(6'h20, 16'h0018);
    wr(6'h21, 16'h0018);
  endtask

  task automatic t_capture();
    wr(6'h22, 16'h1234);
    wr(6'h23, 16'hBEEF);
    wr(6'h10, 16'h0001);            // ch0 rising, timer A
    wr(6'h11, 16'h000A);            // ch1 falling, timer B
    wr(6'h12, 16'h0003);            // ch2 both, timer A
    @(negedge clk); cc_pin_in[2:0] = 3'b111;
    repeat (2) @(negedge clk);
    check("R6 latency two edges", 32'(chv(0)), 0);
    @(negedge clk);
    check("R6 rising capture", 32'(chv(0)), 32'h1234);
    check("R6 falling ignores rise", 32'(chv(1)), 0);
    check("R6 both on rise", 32'(chv(2)), 32'h1234);
    check("R8 capture flags", 32'(cc_irq[2:0]), 32'b101);
    wr(6'h22, 16'h5555);
    @(negedge clk); cc_pin_in[2:0] = 3'b000;
    repeat (3) @(negedge clk);
    check("R7 capture timer B", 32'(chv(1)), 32'hBEEF);
    check("R6 both on fall", 32'(chv(2)), 32'h5555);
    check("R6 rising ignores fall", 32'(chv(0)), 32'h1234);
    check("R8 all flags", 32'(cc_irq[2:0]), 32'b111);
    wr(6'h26, 16'h0007);
    @(negedge clk);
    check("R11 clear", 32'(cc_irq[2:0]), 0);
  endtask

  task automatic t_compare();
    wr(6'h21, 16'h0008);
    wr(6'h23, 16'h0003);
    for (int i = 4; i < 8; i++) wr(6'(i), 16'h0005);
    wr(6'h14, 16'h000C);            // flag only, B
    wr(6'h15, 16'h000D);            // set, B
    wr(6'h16, 16'h000E);            // toggle, B
    wr(6'h17, 16'h0006);            // toggle, A (stopped)
    pulse_b();
    check("R9 no match at 4", 32'(cc_irq[7:4]), 0);
    pulse_b();
    check("R9 flags on match", 32'(cc_irq[7:4]), 32'b0111);
    check("R9 pin actions", 32'(cc_pin_out[7:4]), 32'b0110);
    repeat (10) @(negedge clk);
    check("R10 held value no refire", 32'(cc_pin_out[7:4]), 32'b0110);
    wr(6'h26, 16'h00F0);
    wr(6'h23, 16'h0005);
    repeat (2) @(negedge clk);
    check("R10 direct write no fire", 32'(cc_irq[7:4]), 0);
    wr(6'h25, 16'h0004);
    wr(6'h23, 16'hFFFF);
    pulse_b();
    check("R3 reload to 4", 32'(timer_b), 4);
    pulse_b();
    check("R10 next period fires", 32'(cc_pin_out[7:4]), 32'b0010);
    check("R10 next period flags", 32'(cc_irq[7:4]), 32'b0111);
    wr(6'h20, 16'h0008);
    wr(6'h22, 16'h0004);
    pulse_a();
    check("R7 compare on timer A", 32'(cc_pin_out[7]), 1);
    check("R7 flag on timer A", 32'(cc_irq[7]), 1);
    wr(6'h26, 16'h0010);
    check("R11 masked clear", 32'(cc_irq[7:4]), 32'b1110);
    wr(6'h20, 16'h0018);
    wr(6'h21, 16'h0018);
  endtask

  task automatic t_modes();
    wr(6'h15, 16'h000D);
    check("R12 mode write clears pin", 32'(cc_pin_out[5]), 0);
    wr(6'h19, 16'h0007);            // ch9 reserved, ch8 stays mode 0
    @(negedge clk); cc_pin_in[9:8] = 2'b11;
    repeat (4) @(negedge clk);
    cc_pin_in[9:8] = 2'b00;
    repeat (4) @(negedge clk);
    check("R12 idle modes no capture", 32'(chv(8) | chv(9)), 0);
    check("R12 idle modes no flag", 32'(cc_irq[9:8]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prescaler();
    t_reload();
    t_extcnt();
    t_capture();
    t_compare();
    t_modes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule